// File: doc/BRIEF.md
# SECDED Encoder Lane with Serial Front and Back Ends

This block is one lane of a forward error correction transmitter. Payload bits arrive one per enabled clock on a serial input. A shift chain assembles them into a 120-bit word. On a load strobe the word is copied into an input holding bank, and that bank alone feeds a purely combinational extended Hamming encoder. The encoder produces a 128-bit codeword: seven Hamming check bits plus one overall parity bit. Because the chain is free once its contents have been copied, the next word can start arriving while the current one is being encoded.

On the output side, a capture strobe copies the codeword into an output holding bank. A serial chain, in which every stage can select either its bank bit or its upstream neighbour, then either loads the whole bank at once or shifts it out one bit per enabled clock. Capture, encode and stream-out can therefore overlap with the gathering of later words. A separate flow controller sequences the strobes. This lane only obeys them.

The codeword layout works as follows. Codeword bit 0 is the overall even-parity bit over bits 1 to 127. Bits 1, 2, 4, 8, 16, 32 and 64 are the Hamming check bits. Data bit 0 fills the lowest remaining index (3), and each later data bit fills the next free index up to 127. Every register runs on `clk` with a synchronous active-high reset and plain clock enables.

Top module: `secded_lane`

## Requirements
- R1: After reset, every chain and bank holds zero, so `ser_out` is 0 and an output bank loaded and shifted out right after reset yields 128 zero bits.
- R2: Each cycle with `in_shift` high moves `ser_in` into the top of the input chain. After 120 such shifts, the first bit sent sits at data bit 0 and the last at data bit 119.
- R3: `in_load` copies the input chain into the input holding bank. Further shifts without `in_load` leave the held word, and so the codeword, unchanged.
- R4: Data bit i sits at the (i+1)-th codeword index that is neither 0 nor a power of two. Data bit 0 is at index 3 and data bit 119 at index 127.
- R5: The check bit at index 2^k (k = 0..6) makes the XOR of all codeword bits whose index has bit k set equal to zero. The XOR of the indices of all set bits among 1..127 is therefore 0.
- R6: Codeword bit 0 makes the XOR of all 128 codeword bits zero.
- R7: Flipping any single codeword bit gives odd overall parity. The syndrome (the XOR of the indices of the set bits) then equals the flipped index, or is 0 when bit 0 was flipped.
- R8: Flipping any two distinct codeword bits gives even overall parity with a nonzero syndrome, which marks the word as detected but uncorrectable.
- R9: `out_capture` copies the current codeword into the output holding bank. The bank keeps that value through later `in_load` strobes until the next capture.
- R10: `out_load` copies the output bank into the output chain, so `ser_out` shows codeword bit 0 in the next cycle. `out_load` overrides a simultaneous `out_shift`.
- R11: Each cycle with `out_shift` high and `out_load` low advances the output chain by one bit, so codeword bits leave in ascending index order. Zeros fill in behind them.
- R12: With all enables and strobes low, no register changes and `ser_out` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload bit, least significant first |
| in_shift | input | 1 | Shift enable for the input chain |
| in_load | input | 1 | Copy the input chain into the input holding bank |
| out_capture | input | 1 | Copy the encoder result into the output holding bank |
| out_load | input | 1 | Load the output chain from the output holding bank |
| out_shift | input | 1 | Shift enable for the output chain |
| ser_out | output | 1 | Serial codeword bit, index 0 first |

## Verification
The assertions assume that reset is held for at least one edge and that the strobes are single-cycle pulses whose order is left to the flow controller. They do not assume any spacing between strobes. Concurrent strobe combinations are exercised on purpose: shift with load, capture next to a fresh input load, and load with shift on the output. The bench drives inputs only at falling edges. Its reference model uses the same strobe semantics, so every sequence it applies, including these overlaps, stays inside the stated rules.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest number of Hamming check bits able to cover data_w payload bits.
  function automatic int unsigned ham_checks(input int unsigned data_w);
    int unsigned r;
    r = 1;
    while ((1 << r) < (data_w + r + 1)) r++;
    return r;
  endfunction

  // 1 when idx is a power of two (check-bit slot), 0 otherwise.
  function automatic bit is_pow2(input int unsigned idx);
    return (idx != 0) && ((idx & (idx - 1)) == 0);
  endfunction

endpackage

// File: rtl/lane_sipo.sv
module lane_sipo #(
  parameter int unsigned WIDTH = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             shift_en,
  input  logic             load_en,
  output logic [WIDTH-1:0] held
);

  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] held_q;

  // Serial chain: newest bit enters at the top, so the first bit ends at 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {bit_in, chain_q[WIDTH-1:1]};
    end
  end

  // Holding bank: the only source for the encoder.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (load_en) begin
      held_q <= chain_q;
    end
  end

  assign held = held_q;

  a_r2_entry: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain_q[WIDTH-1] == $past(bit_in));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(held_q));

  a_r12_chain_idle: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q));

endmodule

// File: rtl/lane_parity.sv
module lane_parity
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = 120,
  localparam int unsigned CHK_W  = ham_checks(DATA_W),
  localparam int unsigned CODE_W = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  always_comb begin
    logic [CODE_W-1:0] w;
    logic              acc;
    int unsigned       j;
    w = '0;
    j = 0;
    // Scatter payload across the non-check slots in ascending order.
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p) && (j < DATA_W)) begin
        w[p] = data[j];
        j++;
      end
    end
    // Each check bit evens out the slots whose index has its bit set.
    for (int unsigned k = 0; k < CHK_W; k++) begin
      acc = 1'b0;
      for (int unsigned p = 1; p < CODE_W; p++) begin
        if (((p >> k) & 1) != 0) acc = acc ^ w[p];
      end
      w[1 << k] = acc;
    end
    // Overall parity in slot 0 extends the code to double-error detection.
    w[0] = ^w[CODE_W-1:1];
    code = w;
  end

endmodule

// File: rtl/lane_piso.sv
module lane_piso #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             capture_en,
  input  logic             load_en,
  input  logic             shift_en,
  output logic             bit_out
);

  logic [WIDTH-1:0] bank_q;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (capture_en) begin
      bank_q <= par_in;
    end
  end

  // Per-stage 2:1 select: bank bit on load, upstream neighbour on shift.
  for (genvar s = 0; s < WIDTH; s++) begin : g_stage
    logic upstream;
    if (s == WIDTH - 1) begin : g_top
      assign upstream = 1'b0;
    end else begin : g_mid
      assign upstream = chain_q[s+1];
    end
    assign chain_d[s] = load_en ? bank_q[s] : upstream;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (load_en || shift_en) begin
      chain_q <= chain_d;
    end
  end

  assign bit_out = chain_q[0];

  a_r9_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !capture_en |=> $stable(bank_q));

  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> chain_q == $past(bank_q));

  a_r11_shift: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> chain_q[WIDTH-2:0] == $past(chain_q[WIDTH-1:1]));

  a_r12_out_idle: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load_en) |=> $stable(bit_out));

endmodule

// File: rtl/secded_lane.sv
module secded_lane
  import secded_pkg::*;
#(
  parameter int unsigned DATA_W = 120,
  localparam int unsigned CHK_W  = ham_checks(DATA_W),
  localparam int unsigned CODE_W = DATA_W + CHK_W + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  input  logic in_shift,
  input  logic in_load,
  input  logic out_capture,
  input  logic out_load,
  input  logic out_shift,
  output logic ser_out
);

  logic [DATA_W-1:0] held_word;
  logic [CODE_W-1:0] code_word;

  lane_sipo #(.WIDTH(DATA_W)) u_in (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (ser_in),
    .shift_en (in_shift),
    .load_en  (in_load),
    .held     (held_word)
  );

  lane_parity #(.DATA_W(DATA_W)) u_enc (
    .data (held_word),
    .code (code_word)
  );

  lane_piso #(.WIDTH(CODE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .par_in     (code_word),
    .capture_en (out_capture),
    .load_en    (out_load),
    .shift_en   (out_shift),
    .bit_out    (ser_out)
  );

  // Encoder output must stay even across the whole word between strobes.
  a_r6_even_word: assert property (@(posedge clk) disable iff (rst)
    ^code_word == 1'b0);

  // A fresh input word only reaches the encoder through the load strobe.
  a_r3_code_stable: assert property (@(posedge clk) disable iff (rst)
    !in_load |=> $stable(code_word));

endmodule

// File: tb/tb_secded_lane.sv
`timescale 1ns/1ps
module tb_secded_lane;
  localparam int K = 120;
  localparam int N = 128;

  logic clk = 1'b0;
  logic rst, ser_in, in_shift, in_load, out_capture, out_load, out_shift;
  logic ser_out;
  int   n_run = 0;
  int   n_bad = 0;
  int   cyc = 0;

  always #4 clk = ~clk;

  secded_lane dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .in_shift(in_shift),
    .in_load(in_load), .out_capture(out_capture), .out_load(out_load),
    .out_shift(out_shift), .ser_out(ser_out)
  );

  // Reference encoder: check bits are the XOR of the indices of set data slots.
  function automatic logic [N-1:0] ref_encode(input logic [K-1:0] d);
    logic [N-1:0] w;
    int           i;
    int           syn;
    w = '0; i = 0; syn = 0;
    for (int p = 1; p < N; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p] = d[i];
        if (d[i]) syn = syn ^ p;
        i++;
      end
    end
    for (int k = 0; k < 7; k++) w[1 << k] = syn[k];
    w[0] = ^w;
    return w;
  endfunction

  function automatic logic [K-1:0] extract(input logic [N-1:0] w);
    logic [K-1:0] d;
    int           i;
    d = '0; i = 0;
    for (int p = 1; p < N; p++)
      if ((p & (p - 1)) != 0) begin d[i] = w[p]; i++; end
    return d;
  endfunction

  function automatic int syndrome(input logic [N-1:0] w);
    int s;
    s = 0;
    for (int p = 1; p < N; p++) if (w[p]) s = s ^ p;
    return s;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural cycle model of the lane, compared on every falling edge.
  logic [K-1:0] m_chain, m_hold;
  logic [N-1:0] m_bank, m_och;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_chain <= '0; m_hold <= '0; m_bank <= '0; m_och <= '0;
    end else begin
      if (in_shift) m_chain <= {ser_in, m_chain[K-1:1]};
      if (in_load) m_hold <= m_chain;
      if (out_capture) m_bank <= ref_encode(m_hold);
      if (out_load) m_och <= m_bank;
      else if (out_shift) m_och <= m_och >> 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) check("R10 R11 cycle model", {127'b0, ser_out}, {127'b0, m_och[0]});
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  task automatic clear();
    ser_in = 0; in_shift = 0; in_load = 0; out_capture = 0; out_load = 0; out_shift = 0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk); clear();
    case (which)
      0: in_load = 1;
      1: out_capture = 1;
      2: out_load = 1;
      default: begin out_load = 1; out_shift = 1; end
    endcase
  endtask

  task automatic shift_in(input logic [K-1:0] d, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk); clear(); in_shift = 1; ser_in = d[i];
    end
  endtask

  // Read a codeword serially, optionally feeding the next payload meanwhile.
  task automatic stream(output logic [N-1:0] rx, input bit feed, input logic [K-1:0] nxt);
    rx = '0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk); clear();
      rx[i] = ser_out;
      out_shift = 1;
      if (feed && i < K) begin in_shift = 1; ser_in = nxt[i]; end
    end
  endtask

  task automatic verify_word(input logic [N-1:0] rx, input logic [K-1:0] d);
    logic [N-1:0] e;
    e = ref_encode(d);
    check("R2 payload order", {8'b0, extract(rx)}, {8'b0, d});
    check("R4 slot of data 0 and 119", {126'b0, rx[127], rx[3]}, {126'b0, d[119], d[0]});
    check("R5 zero syndrome", N'(syndrome(rx)), '0);
    check("R6 even word", {127'b0, ^rx}, '0);
    check("R11 full codeword", rx, e);
    for (int t = 0; t < 3; t++) begin
      int pos;
      logic [N-1:0] f;
      pos = (t * 61 + int'(d[6:0])) % N;
      f = rx ^ (N'(1) << pos);
      check("R7 single flip", {120'b0, ^f, 7'(syndrome(f))}, {120'b0, 1'b1, 7'(pos)});
    end
    begin
      int a, b;
      logic [N-1:0] f;
      a = int'(d[13:7]); b = (a + 45) % N;
      f = rx ^ (N'(1) << a) ^ (N'(1) << b);
      check("R8 double flip parity", {127'b0, ^f}, '0);
      check("R8 double flip syndrome nonzero", {127'b0, syndrome(f) != 0}, {127'b0, 1'b1});
    end
  endtask

  initial begin
    logic [K-1:0] words [6];
    logic [K-1:0] junk;
    logic [N-1:0] rx;
    logic         hold_bit;
    clear();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset ser_out", {127'b0, ser_out}, '0);
    strobe(2);
    stream(rx, 0, '0);
    check("R1 reset bank zero", rx, '0);

    words[0] = '0;
    words[1] = '1;
    words[2] = K'(1) << 57;
    for (int i = 3; i < 6; i++) words[i] = {$urandom, $urandom, $urandom, $urandom};
    junk = {$urandom, $urandom, $urandom, $urandom};

    shift_in(words[0], K);
    strobe(0);
    strobe(1);
    strobe(2);
    for (int n = 0; n < 6; n++) begin
      stream(rx, n < 5, (n < 5) ? words[n+1] : '0);
      verify_word(rx, words[n]);
      if (n < 5) begin
        strobe(0);            // next word into holding bank
        shift_in(junk, 13);   // R3: chain moves, held word must not
        strobe(1);            // R9: capture next codeword
        strobe(0);            // R9: reload hold with junk, bank keeps codeword
        @(negedge clk); clear();
        hold_bit = ser_out;
        repeat (3) @(negedge clk);
        check("R12 idle keeps ser_out", {127'b0, ser_out}, {127'b0, hold_bit});
        strobe(3);            // R10: load wins over shift
        @(negedge clk); clear();
        check("R10 load beats shift", {127'b0, ser_out}, {127'b0, ref_encode(words[n+1])[0]});
        // R3/R9 whole-word results are checked by verify_word on the next pass.
        out_shift = 0;
        // the stream below starts one cycle later; re-load so bit 0 is first
        strobe(2);
      end
    end
    @(negedge clk); clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule